// File: doc/BRIEF.md
# Word-Loaded Double-Buffered DAC Code Register

This block sits between a parallel host bus and a 14-bit converter core. A host writes the converter code as two halves into input registers. The upper 6 bits come from bus bits 13..8 and the lower 8 bits come from bus bits 7..0. Each half has its own active-low select, and both halves share an active-low write strobe. A separate active-low load strobe copies the input registers into the DAC register, and that register drives the converter core. Because the code is held in two stages, many instances can be filled one after another and then updated together from a single shared load strobe.

The four strobes and the bus word are asynchronous to the system clock. They pass through a two-flop synchronizer, and from then on they are treated as levels, one evaluation per clock. When every strobe is low the whole path is transparent, so the bus word reaches the DAC register in one step. When a load and an input write fall in the same clock, the write is applied first, so the newly written bits reach the DAC register in that clock.

Top module: `dac_word_loader`

## Requirements
- R1: A synchronous active-high reset clears the upper input register, the lower input register and the DAC register to zero, so the output `dac_code` reads 0.
- R2: With the upper select low, the lower select high, load high and write low, the upper input register takes bus bits 13..8. The lower input register and the DAC register keep their values.
- R3: With the upper select high, the lower select low, load high and write low, the lower input register takes bus bits 7..0. The upper input register and the DAC register keep their values.
- R4: With both selects low, load high and write low, both input registers are written from the bus in the same write, and the DAC register keeps its value.
- R5: With both selects high and load low, the DAC register takes {upper, lower} from the input registers. The write level has no effect on this.
- R6: With both selects, load and write all low, the bus word reaches the DAC register directly, and both input registers are also written.
- R7: When load is high and either write is high or both selects are high, no register changes.
- R8: When load and an input write are active in the same clock, the write is applied first and the DAC register takes the updated input registers. If load stays low after write returns high, the DAC register keeps the data written in that same cycle.
- R9: A change at the inputs that is held steady appears at `dac_code` on the third rising clock edge after it is applied, and not on the second.
- R10: With load low, write high and one or both selects low, no input register is written, and the DAC register takes the existing input register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_data | input | 14 | Parallel code word from the host bus |
| sel_hi_n | input | 1 | Upper-half select, active low |
| sel_lo_n | input | 1 | Lower-half select, active low |
| wr_n | input | 1 | Write strobe, active low |
| ld_n | input | 1 | Load strobe to the DAC register, active low |
| dac_code | output | 14 | DAC register contents driving the converter core |

## Verification
The input registers cannot be seen directly at the ports. A wrong value in one of them stays hidden until the next load, and then `dac_code` shows the wrong half three clocks after the load strobe is applied. For this reason the bench follows each control combination with a load-only cycle, which brings both input registers out to `dac_code`. A fault in the DAC register itself, such as a missed update or an update when none was due, shows at the output three edges after the strobes settle. The bench sweeps all sixteen strobe combinations under several bus words so that each of these paths is exposed.

// File: rtl/dwl_pkg.sv
package dwl_pkg;

  // Strobe levels after synchronization, in the order they are packed.
  typedef struct packed {
    logic sel_hi_n;
    logic sel_lo_n;
    logic ld_n;
    logic wr_n;
  } strobe_t;

  localparam int STROBE_W = $bits(strobe_t);

  // Idle level of the strobe group: all inactive (high).
  localparam strobe_t STROBE_IDLE = '{sel_hi_n: 1'b1, sel_lo_n: 1'b1, ld_n: 1'b1, wr_n: 1'b1};

endpackage

// File: rtl/dwl_sync.sv
module dwl_sync #(
  parameter int              WIDTH   = 4,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[i] <= RST_VAL;
          else     stg[i] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[i] <= RST_VAL;
          else     stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/dwl_decode.sv
module dwl_decode
  import dwl_pkg::*;
(
  input  strobe_t strb,
  output logic    wr_hi,
  output logic    wr_lo,
  output logic    ld
);

  logic wr_act;

  always_comb begin
    wr_act = ~strb.wr_n;
    wr_hi  = wr_act & ~strb.sel_hi_n;
    wr_lo  = wr_act & ~strb.sel_lo_n;
    ld     = ~strb.ld_n;
  end

endmodule

// File: rtl/dwl_regs.sv
module dwl_regs #(
  parameter int CODE_W = 14,
  parameter int LO_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] bus,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic              ld,
  output logic [CODE_W-1:0] dac_q
);

  localparam int HI_W = CODE_W - LO_W;

  logic [HI_W-1:0] hi_q, hi_nx;
  logic [LO_W-1:0] lo_q, lo_nx;

  // A write in the same clock is applied before the transfer.
  always_comb begin
    hi_nx = wr_hi ? bus[CODE_W-1:LO_W] : hi_q;
    lo_nx = wr_lo ? bus[LO_W-1:0]      : lo_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q  <= '0;
      lo_q  <= '0;
      dac_q <= '0;
    end else begin
      hi_q <= hi_nx;
      lo_q <= lo_nx;
      if (ld) dac_q <= {hi_nx, lo_nx};
    end
  end

  // R1: reset clears every stage
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (dac_q == '0 && hi_q == '0 && lo_q == '0));

  // R7: without load the DAC register holds
  p_dac_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !ld |=> $stable(dac_q));

  // R2: upper half changes only on its own write
  p_hi_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !wr_hi |=> $stable(hi_q));

  // R3: lower half changes only on its own write
  p_lo_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !wr_lo |=> $stable(lo_q));

  // R6: all strobes active passes the bus straight through
  p_transparent_r6: assert property (@(posedge clk) disable iff (rst)
    (ld && wr_hi && wr_lo) |=> (dac_q == $past(bus)));

  // R5: a plain load copies the held input registers
  p_load_copy_r5: assert property (@(posedge clk) disable iff (rst)
    (ld && !wr_hi && !wr_lo) |=> (dac_q == {$past(hi_q), $past(lo_q)}));

  // R8: a load alongside an upper write carries the new upper half
  p_load_priority_r8: assert property (@(posedge clk) disable iff (rst)
    (ld && wr_hi) |=> (dac_q[CODE_W-1:LO_W] == $past(bus[CODE_W-1:LO_W])));

endmodule

// File: rtl/dac_word_loader.sv
module dac_word_loader
  import dwl_pkg::*;
#(
  parameter int CODE_W      = 14,
  parameter int LO_W        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] bus_data,
  input  logic              sel_hi_n,
  input  logic              sel_lo_n,
  input  logic              wr_n,
  input  logic              ld_n,
  output logic [CODE_W-1:0] dac_code
);

  strobe_t           strb_raw, strb_s;
  logic [CODE_W-1:0] bus_s;
  logic              wr_hi, wr_lo, ld;

  always_comb begin
    strb_raw.sel_hi_n = sel_hi_n;
    strb_raw.sel_lo_n = sel_lo_n;
    strb_raw.ld_n     = ld_n;
    strb_raw.wr_n     = wr_n;
  end

  // Strobes and data share one synchronizer depth so they stay aligned.
  dwl_sync #(
    .WIDTH  (STROBE_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(STROBE_IDLE)
  ) u_sync_strb (
    .clk(clk),
    .rst(rst),
    .d  (strb_raw),
    .q  (strb_s)
  );

  dwl_sync #(
    .WIDTH  (CODE_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL('0)
  ) u_sync_bus (
    .clk(clk),
    .rst(rst),
    .d  (bus_data),
    .q  (bus_s)
  );

  dwl_decode u_decode (
    .strb (strb_s),
    .wr_hi(wr_hi),
    .wr_lo(wr_lo),
    .ld   (ld)
  );

  dwl_regs #(
    .CODE_W(CODE_W),
    .LO_W  (LO_W)
  ) u_regs (
    .clk  (clk),
    .rst  (rst),
    .bus  (bus_s),
    .wr_hi(wr_hi),
    .wr_lo(wr_lo),
    .ld   (ld),
    .dac_q(dac_code)
  );

endmodule

// File: tb/dac_word_loader_bench.sv
module dac_word_loader_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [13:0] bus_data = '0;
  logic        sel_hi_n = 1'b1;
  logic        sel_lo_n = 1'b1;
  logic        wr_n = 1'b1;
  logic        ld_n = 1'b1;
  logic [13:0] dac_code;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  // Bench model of the three registers.
  logic [5:0]  m_hi = '0;
  logic [7:0]  m_lo = '0;
  logic [13:0] m_dac = '0;

  always #4 clk = ~clk;

  dac_word_loader u_dac_word_loader (
    .clk(clk), .rst(rst), .bus_data(bus_data),
    .sel_hi_n(sel_hi_n), .sel_lo_n(sel_lo_n),
    .wr_n(wr_n), .ld_n(ld_n), .dac_code(dac_code)
  );

  task automatic check(input string tag, input logic [13:0] exp);
    checks++;
    if (dac_code !== exp) begin
      errors++;
      $display("FAIL %s: dac_code=%h expected=%h", tag, dac_code, exp);
    end
  endtask

  task automatic drive(input logic [3:0] c, input logic [13:0] d);
    @(negedge clk);
    sel_hi_n = c[3]; sel_lo_n = c[2]; ld_n = c[1]; wr_n = c[0];
    bus_data = d;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Model one held control state.
  task automatic model(input logic [3:0] c, input logic [13:0] d);
    logic whi, wlo;
    whi = !c[0] && !c[3];
    wlo = !c[0] && !c[2];
    if (whi) m_hi = d[13:8];
    if (wlo) m_lo = d[7:0];
    if (!c[1]) m_dac = {m_hi, m_lo};
  endtask

  function automatic string tag_of(input logic [3:0] c);
    if (c == 4'b0000) return "R6";
    if (!c[1]) begin
      if (!c[0] && (!c[3] || !c[2])) return "R8";
      if (c[3] && c[2]) return "R5";
      return "R10";
    end
    if (c[0] || (c[3] && c[2])) return "R7";
    if (!c[3] && !c[2]) return "R4";
    if (!c[3]) return "R2";
    return "R3";
  endfunction

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
    end
  end

  initial begin
    logic [13:0] d;
    settle(4);
    check("R1", 14'h0000);
    @(negedge clk) rst = 1'b0;
    settle(4);
    check("R1", 14'h0000);

    // R9: latency, visible on the third edge only
    drive(4'b0000, 14'h2a5c);
    settle(2);
    check("R9", 14'h0000);
    settle(1);
    check("R9", 14'h2a5c);
    model(4'b0000, 14'h2a5c);
    drive(4'b1111, 14'h0000);
    settle(4);

    // Sweep of every strobe combination under several bus words.
    for (int k = 0; k < 6; k++) begin
      for (int c = 0; c < 16; c++) begin
        d = 14'((k * 14'h1357) ^ (c * 14'h0a3) ^ 14'h2c1);
        drive(4'(c), d);
        settle(4);
        model(4'(c), d);
        drive(4'b1111, ~d);
        settle(4);
        check(tag_of(4'(c)), m_dac);
        // Load only: exposes both input registers.
        drive(4'b1101, ~d);
        settle(4);
        model(4'b1101, ~d);
        check(tag_of(4'(c)), m_dac);
        drive(4'b1111, d);
        settle(4);
      end
    end

    // R8: load held low after write returns high keeps the new data
    drive(4'b0100, 14'h1b7e);
    settle(3);
    model(4'b0100, 14'h1b7e);
    drive(4'b1101, 14'h0000);
    settle(4);
    model(4'b1101, 14'h0000);
    check("R8", m_dac);
    drive(4'b1111, 14'h0000);
    settle(4);

    // R1: reset clears loaded input registers as well
    drive(4'b0010, 14'h3fff);
    settle(4);
    drive(4'b1111, 14'h3fff);
    settle(4);
    @(negedge clk) rst = 1'b1;
    settle(3);
    @(negedge clk) rst = 1'b0;
    settle(1);
    check("R1", 14'h0000);
    drive(4'b1101, 14'h3fff);
    settle(4);
    check("R1", 14'h0000);

    done = 1'b1;
    finish_run();
  end

endmodule